// File: doc/BRIEF.md
# Prefix-Pair Deduplicating Rule Inserter

This block runs while a classifier's tables are being set up. Each call inserts the source and destination prefix pair of one new rule into one row of the main match table. It does not store every rule's pair. It reads the addressed row and looks for an element that already holds the same pair. If it finds one, it marks that element as shared and writes nothing new. If it does not, it places the pair in the lowest free slot, with the shared mark cleared, and tags it with the new rule's ID.

At the end of each call the block reports three things: the rule ID that now stands for the pair's group, whether the pair was already present, and the slot that holds it. Every main-table row is paired with exactly one auxiliary-table row. Software uses the reported group ID to place the rest of the rule (ports, protocol, priority) in that auxiliary row. The main-table row store is kept inside the block, so the only way to see it is through the results of later insertions.

Top module: `pfx_pair_inserter`

## Requirements
- R1: After reset is asserted, `busy_o`, `done_o`, `shared_o`, `row_full_o`, `slot_o` and `group_rid_o` are all 0, and every row of the table is empty. A first insertion into any row afterwards therefore lands in slot 0, unshared.
- R2: A `start_i` accepted while idle gives `busy_o` high on the following cycle. `done_o` is high for exactly one cycle, four cycles after the accepting edge. The results stay valid from that cycle until the next accepted start.
- R3: A pair not present in a row that has a free slot is written to the lowest-numbered free slot, with its shared flag at 0. The block then reports `shared_o`=0, `row_full_o`=0, `slot_o` equal to that slot and `group_rid_o` equal to `rid_i`.
- R4: A pair already present in the row causes the shared flag of the existing element to be set, and no new element is written. The block reports `shared_o`=1, the slot of the existing element, and the rule ID stored with it, which is the ID of the first rule inserted with that pair.
- R5: Two pairs count as identical only when the source value, source length, destination value and destination length are all equal. A difference in any one of them, including a length alone, makes the pair new.
- R6: A new pair aimed at a row with no free slot writes nothing. The block reports `row_full_o`=1, `shared_o`=0, `slot_o`=0 and `group_rid_o`=0. Pairs already stored in that row are still found as shared afterwards.
- R7: Rows are independent: a pair stored in one row is new to every other row.
- R8: `start_i` while `busy_o` is high is ignored. It neither changes the operation in progress nor inserts its own pair.
- R9: Any number of later insertions of a stored pair keep reporting the first rule's ID and the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the table |
| start_i | input | 1 | Request an insertion; sampled only while idle |
| row_i | input | ROW_AW | Target main-table row |
| src_pfx_i | input | PFX_W | Source prefix value |
| src_len_i | input | LEN_W | Source prefix length |
| dst_pfx_i | input | PFX_W | Destination prefix value |
| dst_len_i | input | LEN_W | Destination prefix length |
| rid_i | input | RID_W | ID of the rule being inserted |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| group_rid_o | output | RID_W | Rule ID representing the pair's group |
| shared_o | output | 1 | Pair was already present in the row |
| slot_o | output | SLOT_AW | Slot holding the pair |
| row_full_o | output | 1 | New pair rejected, row has no free slot |

## Verification
The bench builds the block with 4 rows and 4 slots per row, keeping the 32-bit prefixes, 6-bit lengths and 16-bit rule IDs. With four slots, a single row can be filled by a short run of distinct pairs. That brings the full-row rejection and the later lookups in a full row within reach. Having several rows lets the bench show that the same pair is new in a second row, and gives each directed test a clean row.

// File: rtl/pfx_ins_pkg.sv
package pfx_ins_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CMP,
    ST_WRITE,
    ST_DONE
  } ins_state_e;
endpackage

// File: rtl/pfx_row_store.sv
module pfx_row_store #(
  parameter int ROWS     = 16,
  parameter int ROW_BITS = 64,
  parameter int ROW_AW   = $clog2(ROWS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  logic [ROW_AW-1:0]   rd_addr_i,
  output logic [ROW_BITS-1:0] rd_data_o,
  input  logic                wr_en_i,
  input  logic [ROW_AW-1:0]   wr_addr_i,
  input  logic [ROW_BITS-1:0] wr_data_i
);
  logic [ROW_BITS-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ROWS; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  // one-cycle read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && wr_en_i)); // R2
endmodule

// File: rtl/pfx_pair_match.sv
module pfx_pair_match #(
  parameter int SLOTS   = 8,
  parameter int PFX_W   = 32,
  parameter int LEN_W   = 6,
  parameter int RID_W   = 16,
  parameter int SLOT_AW = $clog2(SLOTS),
  parameter int ELEM_W  = 2 + 2*PFX_W + 2*LEN_W + RID_W
) (
  input  logic [SLOTS*ELEM_W-1:0] row_i,
  input  logic [PFX_W-1:0]        src_pfx_i,
  input  logic [LEN_W-1:0]        src_len_i,
  input  logic [PFX_W-1:0]        dst_pfx_i,
  input  logic [LEN_W-1:0]        dst_len_i,
  output logic [SLOTS-1:0]        hit_vec_o,
  output logic                    hit_any_o,
  output logic [SLOT_AW-1:0]      hit_idx_o,
  output logic [RID_W-1:0]        hit_rid_o,
  output logic                    free_any_o,
  output logic [SLOT_AW-1:0]      free_idx_o
);
  typedef struct packed {
    logic             valid;
    logic             shared;
    logic [PFX_W-1:0] src;
    logic [LEN_W-1:0] slen;
    logic [PFX_W-1:0] dst;
    logic [LEN_W-1:0] dlen;
    logic [RID_W-1:0] rid;
  } elem_t;

  logic [SLOTS-1:0] free_vec;
  logic [RID_W-1:0] rid_arr [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    elem_t e;
    assign e            = row_i[g*ELEM_W +: ELEM_W];
    assign hit_vec_o[g] = e.valid && (e.src == src_pfx_i) && (e.slen == src_len_i)
                          && (e.dst == dst_pfx_i) && (e.dlen == dst_len_i);
    assign free_vec[g]  = !e.valid;
    assign rid_arr[g]   = e.rid;
  end

  // lowest index wins
  always_comb begin
    hit_idx_o  = '0;
    free_idx_o = '0;
    for (int i = SLOTS-1; i >= 0; i--) begin
      if (hit_vec_o[i]) hit_idx_o  = SLOT_AW'(i);
      if (free_vec[i])  free_idx_o = SLOT_AW'(i);
    end
  end

  assign hit_any_o  = |hit_vec_o;
  assign free_any_o = |free_vec;
  assign hit_rid_o  = rid_arr[hit_idx_o];
endmodule

// File: rtl/pfx_insert_fsm.sv
module pfx_insert_fsm
  import pfx_ins_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int SLOTS    = 8,
  parameter int PFX_W    = 32,
  parameter int LEN_W    = 6,
  parameter int RID_W    = 16,
  parameter int ROW_AW   = $clog2(ROWS),
  parameter int SLOT_AW  = $clog2(SLOTS),
  parameter int ELEM_W   = 2 + 2*PFX_W + 2*LEN_W + RID_W,
  parameter int ROW_BITS = SLOTS*ELEM_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [ROW_AW-1:0]   row_i,
  input  logic [PFX_W-1:0]    src_pfx_i,
  input  logic [LEN_W-1:0]    src_len_i,
  input  logic [PFX_W-1:0]    dst_pfx_i,
  input  logic [LEN_W-1:0]    dst_len_i,
  input  logic [RID_W-1:0]    rid_i,
  output logic                rd_en_o,
  output logic [ROW_AW-1:0]   rd_addr_o,
  input  logic [ROW_BITS-1:0] rd_data_i,
  output logic                wr_en_o,
  output logic [ROW_AW-1:0]   wr_addr_o,
  output logic [ROW_BITS-1:0] wr_data_o,
  output logic [PFX_W-1:0]    key_src_o,
  output logic [LEN_W-1:0]    key_slen_o,
  output logic [PFX_W-1:0]    key_dst_o,
  output logic [LEN_W-1:0]    key_dlen_o,
  input  logic [SLOTS-1:0]    hit_vec_i,
  input  logic                hit_any_i,
  input  logic [SLOT_AW-1:0]  hit_idx_i,
  input  logic [RID_W-1:0]    hit_rid_i,
  input  logic                free_any_i,
  input  logic [SLOT_AW-1:0]  free_idx_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [RID_W-1:0]    group_rid_o,
  output logic                shared_o,
  output logic [SLOT_AW-1:0]  slot_o,
  output logic                row_full_o
);
  localparam int SHARED_BIT = ELEM_W - 2;

  ins_state_e            state_q;
  logic [ROW_AW-1:0]     row_q;
  logic [PFX_W-1:0]      src_q, dst_q;
  logic [LEN_W-1:0]      slen_q, dlen_q;
  logic [RID_W-1:0]      rid_q;
  logic [ROW_BITS-1:0]   row_next, wr_row_q;
  logic [ELEM_W-1:0]     new_elem;

  assign new_elem = {1'b1, 1'b0, src_q, slen_q, dst_q, dlen_q, rid_q};

  always_comb begin
    row_next = rd_data_i;
    if (hit_any_i)       row_next[hit_idx_i*ELEM_W + SHARED_BIT] = 1'b1;
    else if (free_any_i) row_next[free_idx_i*ELEM_W +: ELEM_W]   = new_elem;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      row_q       <= '0;
      src_q       <= '0;
      dst_q       <= '0;
      slen_q      <= '0;
      dlen_q      <= '0;
      rid_q       <= '0;
      wr_row_q    <= '0;
      shared_o    <= 1'b0;
      row_full_o  <= 1'b0;
      slot_o      <= '0;
      group_rid_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          row_q   <= row_i;
          src_q   <= src_pfx_i;
          slen_q  <= src_len_i;
          dst_q   <= dst_pfx_i;
          dlen_q  <= dst_len_i;
          rid_q   <= rid_i;
          state_q <= ST_READ;
        end
        ST_READ: state_q <= ST_CMP;
        ST_CMP: begin
          shared_o    <= hit_any_i;
          row_full_o  <= !hit_any_i && !free_any_i;
          slot_o      <= hit_any_i ? hit_idx_i : (free_any_i ? free_idx_i : '0);
          group_rid_o <= hit_any_i ? hit_rid_i : (free_any_i ? rid_q : '0);
          wr_row_q    <= row_next;
          state_q     <= ST_WRITE;
        end
        ST_WRITE: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en_o    = (state_q == ST_READ);
  assign rd_addr_o  = row_q;
  assign wr_en_o    = (state_q == ST_WRITE) && !row_full_o;
  assign wr_addr_o  = row_q;
  assign wr_data_o  = wr_row_q;
  assign key_src_o  = src_q;
  assign key_slen_o = slen_q;
  assign key_dst_o  = dst_q;
  assign key_dlen_o = dlen_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_NEW_PAIR_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !row_full_o) |-> $past(wr_en_o)); // R3
  AST_HIT_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP) |-> $onehot0(hit_vec_i)); // R4
  AST_FULL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && row_full_o) |-> !$past(wr_en_o)); // R6
  AST_FULL_NOT_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(shared_o && row_full_o)); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(row_q) && $stable(rid_q) && $stable(src_q))); // R8
endmodule

// File: rtl/pfx_pair_inserter.sv
module pfx_pair_inserter
  import pfx_ins_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int SLOTS   = 8,
  parameter int PFX_W   = 32,
  parameter int LEN_W   = 6,
  parameter int RID_W   = 16,
  parameter int ROW_AW  = $clog2(ROWS),
  parameter int SLOT_AW = $clog2(SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ROW_AW-1:0]  row_i,
  input  logic [PFX_W-1:0]   src_pfx_i,
  input  logic [LEN_W-1:0]   src_len_i,
  input  logic [PFX_W-1:0]   dst_pfx_i,
  input  logic [LEN_W-1:0]   dst_len_i,
  input  logic [RID_W-1:0]   rid_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [RID_W-1:0]   group_rid_o,
  output logic               shared_o,
  output logic [SLOT_AW-1:0] slot_o,
  output logic               row_full_o
);
  localparam int ELEM_W   = 2 + 2*PFX_W + 2*LEN_W + RID_W;
  localparam int ROW_BITS = SLOTS * ELEM_W;

  logic                rd_en, wr_en;
  logic [ROW_AW-1:0]   rd_addr, wr_addr;
  logic [ROW_BITS-1:0] rd_data, wr_data;
  logic [PFX_W-1:0]    key_src, key_dst;
  logic [LEN_W-1:0]    key_slen, key_dlen;
  logic [SLOTS-1:0]    hit_vec;
  logic                hit_any, free_any;
  logic [SLOT_AW-1:0]  hit_idx, free_idx;
  logic [RID_W-1:0]    hit_rid;

  pfx_row_store #(.ROWS(ROWS), .ROW_BITS(ROW_BITS), .ROW_AW(ROW_AW)) u_store (
    .clk_i, .rst_ni,
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data)
  );

  pfx_pair_match #(.SLOTS(SLOTS), .PFX_W(PFX_W), .LEN_W(LEN_W), .RID_W(RID_W),
                   .SLOT_AW(SLOT_AW), .ELEM_W(ELEM_W)) u_match (
    .row_i(rd_data),
    .src_pfx_i(key_src), .src_len_i(key_slen),
    .dst_pfx_i(key_dst), .dst_len_i(key_dlen),
    .hit_vec_o(hit_vec), .hit_any_o(hit_any), .hit_idx_o(hit_idx),
    .hit_rid_o(hit_rid), .free_any_o(free_any), .free_idx_o(free_idx)
  );

  pfx_insert_fsm #(.ROWS(ROWS), .SLOTS(SLOTS), .PFX_W(PFX_W), .LEN_W(LEN_W),
                   .RID_W(RID_W), .ROW_AW(ROW_AW), .SLOT_AW(SLOT_AW),
                   .ELEM_W(ELEM_W), .ROW_BITS(ROW_BITS)) u_fsm (
    .clk_i, .rst_ni, .start_i, .row_i,
    .src_pfx_i, .src_len_i, .dst_pfx_i, .dst_len_i, .rid_i,
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .key_src_o(key_src), .key_slen_o(key_slen),
    .key_dst_o(key_dst), .key_dlen_o(key_dlen),
    .hit_vec_i(hit_vec), .hit_any_i(hit_any), .hit_idx_i(hit_idx),
    .hit_rid_i(hit_rid), .free_any_i(free_any), .free_idx_i(free_idx),
    .busy_o, .done_o, .group_rid_o, .shared_o, .slot_o, .row_full_o
  );
endmodule

// File: tb/pfx_pair_inserter_bench.sv
`timescale 1ns/1ps
module pfx_pair_inserter_bench;
  localparam int ROWS = 4, SLOTS = 4, PFX_W = 32, LEN_W = 6, RID_W = 16;

  logic        clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [1:0]  row = '0;
  logic [31:0] sp = '0, dp = '0;
  logic [5:0]  sl = '0, dl = '0;
  logic [15:0] rid = '0;
  logic        busy, done, shared, full;
  logic [15:0] grid;
  logic [1:0]  slot;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pfx_pair_inserter #(.ROWS(ROWS), .SLOTS(SLOTS), .PFX_W(PFX_W), .LEN_W(LEN_W),
                      .RID_W(RID_W)) u_pfx_pair_inserter (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .row_i(row),
    .src_pfx_i(sp), .src_len_i(sl), .dst_pfx_i(dp), .dst_len_i(dl), .rid_i(rid),
    .busy_o(busy), .done_o(done), .group_rid_o(grid), .shared_o(shared),
    .slot_o(slot), .row_full_o(full)
  );

  typedef struct packed {
    logic [1:0]  row;
    logic [31:0] sp;
    logic [5:0]  sl;
    logic [31:0] dp;
    logic [5:0]  dl;
    logic [15:0] rid;
    logic        sh;
    logic        full;
    logic [1:0]  slot;
    logic [15:0] grid;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  // pair A: 0A000000/8 -> C0A80000/16
  localparam vec_t VECS [NV] = '{
    '{2'd1, 32'h0A000000, 6'd8,  32'hC0A80000, 6'd16, 16'h0101, 1'b0, 1'b0, 2'd0, 16'h0101, 8'd3}, // R3 new A
    '{2'd1, 32'h0A000000, 6'd8,  32'hC0A80000, 6'd16, 16'h0102, 1'b1, 1'b0, 2'd0, 16'h0101, 8'd4}, // R4 A again
    '{2'd1, 32'h0A000000, 6'd9,  32'hC0A80000, 6'd16, 16'h0103, 1'b0, 1'b0, 2'd1, 16'h0103, 8'd5}, // R5 length differs
    '{2'd1, 32'h0A000000, 6'd8,  32'hC0A90000, 6'd16, 16'h0104, 1'b0, 1'b0, 2'd2, 16'h0104, 8'd5}, // R5 dst differs
    '{2'd1, 32'h0A000000, 6'd8,  32'hC0A80000, 6'd16, 16'h0105, 1'b1, 1'b0, 2'd0, 16'h0101, 8'd9}, // R9 A third
    '{2'd1, 32'hAC100000, 6'd12, 32'h00000000, 6'd0,  16'h0106, 1'b0, 1'b0, 2'd3, 16'h0106, 8'd3}, // R3 last slot
    '{2'd1, 32'h01020304, 6'd32, 32'h05060708, 6'd32, 16'h0107, 1'b0, 1'b1, 2'd0, 16'h0000, 8'd6}, // R6 full
    '{2'd1, 32'h01020304, 6'd32, 32'h05060708, 6'd32, 16'h0108, 1'b0, 1'b1, 2'd0, 16'h0000, 8'd6}, // R6 not written
    '{2'd1, 32'h0A000000, 6'd9,  32'hC0A80000, 6'd16, 16'h0109, 1'b1, 1'b0, 2'd1, 16'h0103, 8'd6}, // R6 found in full row
    '{2'd2, 32'h0A000000, 6'd8,  32'hC0A80000, 6'd16, 16'h0200, 1'b0, 1'b0, 2'd0, 16'h0200, 8'd7}, // R7 other row
    '{2'd2, 32'h0A000000, 6'd8,  32'hC0A80000, 6'd16, 16'h0201, 1'b1, 1'b0, 2'd0, 16'h0200, 8'd7}, // R7
    '{2'd2, 32'h01020304, 6'd32, 32'h05060708, 6'd32, 16'h0202, 1'b0, 1'b0, 2'd1, 16'h0202, 8'd7}  // R7
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_ins(input logic [1:0] r, input logic [31:0] s, input logic [5:0] slen,
                        input logic [31:0] d, input logic [5:0] dlen, input logic [15:0] id,
                        output int lat, output logic busy1);
    @(negedge clk);
    start = 1'b1; row = r; sp = s; sl = slen; dp = d; dl = dlen; rid = id;
    @(negedge clk);
    start = 1'b0;
    lat = 1; busy1 = busy;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic chk_res(input string tag, input logic sh, input logic fl,
                         input logic [1:0] sl_e, input logic [15:0] g);
    chk(tag, "shared", 32'(shared), 32'(sh));
    chk(tag, "row_full", 32'(full), 32'(fl));
    chk(tag, "slot", 32'(slot), 32'(sl_e));
    chk(tag, "group_rid", 32'(grid), 32'(g));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    logic b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chk_res("R1", 1'b0, 1'b0, 2'd0, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "busy after release", 32'(busy), 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      do_ins(VECS[i].row, VECS[i].sp, VECS[i].sl, VECS[i].dp, VECS[i].dl, VECS[i].rid, lat, b1);
      chk(tag, "latency", 32'(lat), 4);
      chk_res(tag, VECS[i].sh, VECS[i].full, VECS[i].slot, VECS[i].grid);
    end

    // R2 handshake timing and one-cycle done
    do_ins(2'd0, 32'h11110000, 6'd16, 32'h22220000, 6'd16, 16'h0001, lat, b1);
    chk("R2", "busy next cycle", 32'(b1), 1);
    chk("R2", "done latency", 32'(lat), 4);
    @(negedge clk);
    chk("R2", "done one cycle", 32'(done), 0);
    chk("R2", "busy cleared", 32'(busy), 0);
    chk("R2", "result held", 32'(grid), 32'h0001);

    // R8 start while busy ignored
    @(negedge clk);
    start = 1'b1; row = 2'd3; sp = 32'h33330000; sl = 6'd16; dp = 32'h44440000; dl = 6'd16; rid = 16'h0300;
    @(negedge clk);
    start = 1'b1; row = 2'd3; sp = 32'h55550000; sl = 6'd16; dp = 32'h66660000; dl = 6'd16; rid = 16'h0301;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk_res("R8 in-flight", 1'b0, 1'b0, 2'd0, 16'h0300);
    do_ins(2'd3, 32'h55550000, 6'd16, 32'h66660000, 6'd16, 16'h0301, lat, b1);
    chk_res("R8 ignored pair absent", 1'b0, 1'b0, 2'd1, 16'h0301);
    do_ins(2'd3, 32'h33330000, 6'd16, 32'h44440000, 6'd16, 16'h0302, lat, b1);
    chk_res("R8 first pair kept", 1'b1, 1'b0, 2'd0, 16'h0300);

    // R1 reset clears the table
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk_res("R1 after reset", 1'b0, 1'b0, 2'd0, 16'h0);
    rst_ni = 1'b1;
    do_ins(2'd1, 32'hAC100000, 6'd12, 32'h00000000, 6'd0, 16'h0900, lat, b1);
    chk_res("R1 table empty", 1'b0, 1'b0, 2'd0, 16'h0900);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule